// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is an on-chip model of a three-wire serial EEPROM slave holding 16-bit words. A host drives a chip select, a serial clock and a serial data line. The block recognises a start bit and collects a two-bit command code and an address field. It then reads words out bit by bit or modifies the array. Reads continue into the following words for as long as the serial clock keeps running. Every command that changes the array is gated by a write-enable latch. Two subcommands set and clear that latch. After a modifying command, a programming interval runs. While it runs, the data output reports busy and then ready whenever the host selects the part.

The serial pins are sampled in the system clock domain, and the serial clock's rising edges are found by edge detection. The array is a register array that resets to all ones. The programming interval is a cycle count, so simulation can shorten it. The word count and the number of address clocks are parameters: 64 words with 6 address clocks, or 128/256 words with 8 address clocks. In the 128-word case the leading address bit is ignored.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is high and no frame is open, serial clock rising edges with data-in low are ignored. The first rising edge with data-in high is the start bit.
- R2: The two bits after the start bit select the command: 10 read, 01 write, 11 erase. 00 means a subcommand taken from the next two bits: 01 write-all, 10 erase-all, 11 enable writes, 00 disable writes.
- R3: For a read, the address arrives MSB first (6 bits at default parameters). From the edge that samples the last address bit, the output drives the addressed word MSB first. It moves one bit per further rising serial clock edge, and the output enable is high.
- R4: After bit 0 of a word, the next rising edge presents bit 15 of the next address. The address wraps from the last word to word 0.
- R5: A write frame is the start bit, the command, the address and exactly 16 data bits (MSB first). It stores the data when chip select falls, and this starts a programming interval of PROG_CYCLES clock cycles.
- R6: The write-enable latch is clear after reset. While it is clear, write, erase, write-all and erase-all leave the array unchanged and start no programming interval.
- R7: Erase sets the addressed word to all ones. Write-all stores its 16 data bits in every word. Erase-all sets every word to all ones. The array holds all ones after reset.
- R8: A modifying frame whose bit count differs from the one its command needs is discarded when chip select falls.
- R9: When chip select rises during programming, the output is enabled and driven low. It goes high once programming ends. Frames sent during programming are ignored.
- R10: The output enable is low while chip select is low, and also while no read is active and no status is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipSel | input | 1 | Chip select, active high |
| serClk | input | 1 | Serial clock; rising edges sample serIn |
| serIn | input | 1 | Serial data in |
| serOut | output | 1 | Serial data out / busy-ready status |
| serOutEn | output | 1 | Output enable for serOut (low = high impedance) |

## Verification
A wrong bit counter or command register shows up at the next read. The data comes out shifted by whole bits, or comes from the wrong word, and the scoreboard compares every output bit on the edge that produces it. A stuck or wrongly set write-enable latch shows up through the status check. The bench raises chip select right after each modifying frame and expects busy or no drive within two cycles. A later read-back then exposes the array contents. A timer of the wrong length is caught by the ready sample taken a fixed number of cycles later.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  localparam int MW_WORD_W = 16;

  typedef enum logic [1:0] {
    OP_SUB   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mwOp_t;

  typedef enum logic [1:0] {
    SUB_WDIS = 2'b00,
    SUB_WALL = 2'b01,
    SUB_EALL = 2'b10,
    SUB_WEN  = 2'b11
  } mwSub_t;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic shiftAddr;
    logic shiftData;
    logic loadRead;
    logic advRead;
    logic progWord;
    logic progAll;
    logic useOnes;
  } mwStrobe_t;

endpackage

// File: rtl/mw_eeprom_dpath.sv
module mw_eeprom_dpath
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int ADDR_CLKS = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      serIn,
  input  mwStrobe_t strobe,
  output logic      dataBit
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int BIT_W = $clog2(MW_WORD_W);

  logic [ADDR_CLKS-1:0] addrSh;
  logic [ADDR_CLKS-1:0] nextAddr;
  logic [MW_WORD_W-1:0] dataSh;
  logic [MW_WORD_W-1:0] outSh;
  logic [MW_WORD_W-1:0] progVal;
  logic [BIT_W-1:0]     outPos;
  logic [ADDR_W-1:0]    rdAddr;
  logic [ADDR_W-1:0]    nextRd;
  logic [ADDR_W-1:0]    hdrIdx;
  logic [ADDR_W-1:0]    progIdx;
  logic [MW_WORD_W-1:0] mem [WORDS];

  assign nextAddr = {addrSh[ADDR_CLKS-2:0], serIn};
  assign hdrIdx   = nextAddr[ADDR_W-1:0];
  assign progIdx  = addrSh[ADDR_W-1:0];
  assign progVal  = strobe.useOnes ? '1 : dataSh;
  assign nextRd   = rdAddr + 1'b1;
  assign dataBit  = outSh[MW_WORD_W-1];

  // one storage row per word
  for (genvar w = 0; w < WORDS; w++) begin : gRow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[w] <= '1;
      end else if (strobe.progAll ||
                   (strobe.progWord && progIdx == ADDR_W'(w))) begin
        mem[w] <= progVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrSh <= '0;
      dataSh <= '0;
      outSh  <= '0;
      outPos <= '0;
      rdAddr <= '0;
    end else begin
      if (strobe.shiftAddr) addrSh <= nextAddr;
      if (strobe.shiftData) dataSh <= {dataSh[MW_WORD_W-2:0], serIn};
      if (strobe.loadRead) begin
        rdAddr <= hdrIdx;
        outSh  <= mem[hdrIdx];
        outPos <= '0;
      end else if (strobe.advRead) begin
        if (outPos == BIT_W'(MW_WORD_W - 1)) begin
          rdAddr <= nextRd;
          outSh  <= mem[nextRd];
          outPos <= '0;
        end else begin
          outSh  <= {outSh[MW_WORD_W-2:0], 1'b0};
          outPos <= outPos + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_CLKS   = 6,
  parameter int PROG_CYCLES = 200000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      chipSel,
  input  logic      serClk,
  input  logic      serIn,
  input  logic      dataBit,
  output mwStrobe_t strobe,
  output logic      serOut,
  output logic      serOutEn,
  output logic      progBusy,
  output logic      welLatch
);

  localparam int HDR_BITS  = 2 + ADDR_CLKS;
  localparam int FULL_BITS = HDR_BITS + MW_WORD_W;
  localparam int FRAME_MAX = FULL_BITS + 1;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int TMR_W     = $clog2(PROG_CYCLES + 1);

  logic             csPrev, skPrev;
  logic             frameOn, readActive, statusShow;
  logic [CNT_W-1:0] cnt;
  mwOp_t            op;
  mwSub_t           sub;
  logic [TMR_W-1:0] tmr;
  logic             skRise, csFall, csRise, busy;
  logic             startHit, bitHit, welSet, welClr;
  logic             hdrOnly, withData;

  assign skRise   = chipSel & serClk & ~skPrev;
  assign csFall   = ~chipSel & csPrev;
  assign csRise   = chipSel & ~csPrev;
  assign busy     = (tmr != '0);
  assign startHit = skRise & ~frameOn & ~busy & serIn;
  assign bitHit   = skRise & frameOn;
  assign hdrOnly  = (cnt == CNT_W'(HDR_BITS));
  assign withData = (cnt == CNT_W'(FULL_BITS));

  always_comb begin
    strobe = '0;
    welSet = 1'b0;
    welClr = 1'b0;
    if (bitHit) begin
      if (cnt >= CNT_W'(2) && cnt < CNT_W'(HDR_BITS)) strobe.shiftAddr = 1'b1;
      if (cnt == CNT_W'(HDR_BITS - 1) && op == OP_READ) strobe.loadRead = 1'b1;
      if (readActive) strobe.advRead = 1'b1;
      if (cnt >= CNT_W'(HDR_BITS) && cnt < CNT_W'(FULL_BITS)) strobe.shiftData = 1'b1;
    end
    if (csFall && frameOn) begin
      unique case (op)
        OP_WRITE: strobe.progWord = withData & welLatch;
        OP_ERASE: begin
          strobe.progWord = hdrOnly & welLatch;
          strobe.useOnes  = 1'b1;
        end
        OP_READ: ;
        OP_SUB: begin
          unique case (sub)
            SUB_WALL: strobe.progAll = withData & welLatch;
            SUB_EALL: begin
              strobe.progAll = hdrOnly & welLatch;
              strobe.useOnes = 1'b1;
            end
            SUB_WEN:  welSet = hdrOnly;
            SUB_WDIS: welClr = hdrOnly;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev     <= 1'b0;
      skPrev     <= 1'b0;
      frameOn    <= 1'b0;
      readActive <= 1'b0;
      statusShow <= 1'b0;
      cnt        <= '0;
      op         <= OP_SUB;
      sub        <= SUB_WDIS;
      tmr        <= '0;
      welLatch   <= 1'b0;
    end else begin
      csPrev <= chipSel;
      skPrev <= serClk;
      if (busy) tmr <= tmr - 1'b1;
      if (strobe.progWord || strobe.progAll) tmr <= TMR_W'(PROG_CYCLES);
      if (welSet) welLatch <= 1'b1;
      if (welClr) welLatch <= 1'b0;
      if (!chipSel) begin
        frameOn    <= 1'b0;
        readActive <= 1'b0;
        statusShow <= 1'b0;
      end else begin
        if (csRise && busy) statusShow <= 1'b1;
        if (startHit) begin
          frameOn    <= 1'b1;
          cnt        <= '0;
          statusShow <= 1'b0;
        end else if (bitHit) begin
          if (cnt != CNT_W'(FRAME_MAX)) cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(0)) op  <= mwOp_t'({serIn, 1'b0});
          if (cnt == CNT_W'(1)) op  <= mwOp_t'({op[1], serIn});
          if (cnt == CNT_W'(2)) sub <= mwSub_t'({serIn, 1'b0});
          if (cnt == CNT_W'(3)) sub <= mwSub_t'({sub[1], serIn});
          if (strobe.loadRead) readActive <= 1'b1;
        end
      end
    end
  end

  assign progBusy = busy;
  assign serOut   = statusShow ? ~busy : dataBit;
  assign serOutEn = chipSel & (statusShow | readActive);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int ADDR_CLKS   = 6,
  parameter int PROG_CYCLES = 200000
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic serClk,
  input  logic serIn,
  output logic serOut,
  output logic serOutEn
);

  mwStrobe_t strobe;
  logic      dataBit;
  logic      progBusy;
  logic      welLatch;

  mw_eeprom_ctrl #(
    .ADDR_CLKS  (ADDR_CLKS),
    .PROG_CYCLES(PROG_CYCLES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .chipSel (chipSel),
    .serClk  (serClk),
    .serIn   (serIn),
    .dataBit (dataBit),
    .strobe  (strobe),
    .serOut  (serOut),
    .serOutEn(serOutEn),
    .progBusy(progBusy),
    .welLatch(welLatch)
  );

  mw_eeprom_dpath #(
    .ADDR_W   (ADDR_W),
    .ADDR_CLKS(ADDR_CLKS)
  ) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .serIn  (serIn),
    .strobe (strobe),
    .dataBit(dataBit)
  );

endmodule

// File: rtl/mw_eeprom_checks.sv
module mw_eeprom_checks (
  input logic clk,
  input logic rstN,
  input logic chipSel,
  input logic serOut,
  input logic serOutEn,
  input logic progBusy,
  input logic welLatch
);

  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |-> !serOutEn); // R10

  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (progBusy && serOutEn) |-> !serOut); // R9

  AST_WEL_STABLE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    chipSel |=> $stable(welLatch)); // R6

  AST_PROG_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progBusy) |-> !$past(chipSel)); // R5

  AST_PROG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progBusy) |-> $past(welLatch)); // R6

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    serOutEn |-> !$isunknown(serOut)); // R3

endmodule

bind mw_eeprom mw_eeprom_checks chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .chipSel (chipSel),
  .serOut  (serOut),
  .serOutEn(serOutEn),
  .progBusy(progBusy),
  .welLatch(welLatch)
);

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;

  localparam int PROG  = 400;
  localparam int WORDS = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0;
  logic serClk = 1'b0;
  logic serIn = 1'b0;
  logic serOut, serOutEn;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [WORDS];
  logic welM = 1'b0;
  logic expQ[$];
  string curTag = "R3";
  event sampleEv;

  always #10 clk = ~clk;

  mw_eeprom #(.ADDR_W(6), .ADDR_CLKS(6), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk),
    .serIn(serIn), .serOut(serOut), .serOutEn(serOutEn)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected output bit per sample event
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() == 0) begin
        check(1'b0, curTag, 0, 1);
      end else begin
        logic e;
        e = expQ.pop_front();
        check(serOutEn === 1'b1 && serOut === e, curTag, {serOutEn, serOut}, {1'b1, e});
      end
    end
  end

  task automatic csOn();
    @(negedge clk) chipSel = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic csOff();
    @(negedge clk) begin chipSel = 1'b0; serIn = 1'b0; end
    repeat (3) @(negedge clk);
  endtask

  task automatic clockBit(input logic b);
    serIn = b;
    repeat (2) @(negedge clk);
    serClk = 1'b1;
    repeat (3) @(negedge clk);
    serClk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] bits, input int n, input int dummies);
    for (int i = 0; i < dummies; i++) clockBit(1'b0);
    for (int i = n - 1; i >= 0; i--) clockBit(bits[i]);
  endtask

  task automatic runFrame(input logic [31:0] bits, input int n, input int dummies);
    csOn();
    sendBits(bits, n, dummies);
    csOff();
  endtask

  // after a modifying frame: busy low, then ready high
  task automatic checkStatus(input string tag);
    csOn();
    check(serOutEn === 1'b1 && serOut === 1'b0, tag, {serOutEn, serOut}, 2'b10);
    repeat (PROG + 10) @(negedge clk);
    check(serOutEn === 1'b1 && serOut === 1'b1, tag, {serOutEn, serOut}, 2'b11);
    csOff();
  endtask

  task automatic checkIdle(input string tag);
    csOn();
    check(serOutEn === 1'b0, tag, serOutEn, 0);
    csOff();
  endtask

  task automatic readWords(input int addr, input int n, input int dummies, input string tag);
    curTag = tag;
    csOn();
    sendBits({23'd0, 1'b1, 2'b10, 6'(addr)}, 9, dummies);
    for (int w = 0; w < n; w++) begin
      for (int b = 15; b >= 0; b--) begin
        expQ.push_back(model[(addr + w) % WORDS][b]);
        ->sampleEv;
        #1;
        if (!(w == n - 1 && b == 0)) clockBit(1'b0);
      end
    end
    csOff();
    check(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  task automatic doWrite(input int addr, input logic [15:0] d, input int dummies, input string tag);
    runFrame({7'd0, 1'b1, 2'b01, 6'(addr), d}, 25, dummies);
    if (welM) begin model[addr] = d; checkStatus(tag); end
    else checkIdle(tag);
  endtask

  task automatic doSub(input logic [1:0] s, input logic [15:0] d, input string tag);
    if (s == 2'b01) runFrame({7'd0, 1'b1, 2'b00, s, 4'b0, d}, 25, 0);
    else runFrame({23'd0, 1'b1, 2'b00, s, 4'b0}, 9, 0);
    if (s == 2'b11) welM = 1'b1;
    else if (s == 2'b00) welM = 1'b0;
    else if (welM) begin
      for (int i = 0; i < WORDS; i++) model[i] = (s == 2'b01) ? d : 16'hFFFF;
      checkStatus(tag);
    end else checkIdle(tag);
  endtask

  initial begin
    #(20ns * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(serOutEn === 1'b0, "R10 reset", serOutEn, 0);
    checkIdle("R10 selected no frame");

    readWords(5, 1, 0, "R7 reset contents");
    doWrite(5, 16'h1234, 0, "R6 latch clear");
    readWords(5, 1, 0, "R6 gated write");
    doSub(2'b10, 16'h0, "R6 gated erase-all");

    doSub(2'b11, 16'h0, "R2 enable");
    doWrite(5, 16'hA5C3, 3, "R1 dummy clocks");
    readWords(5, 1, 2, "R5 write readback");
    doWrite(6, 16'h0F0F, 0, "R5");
    doWrite(63, 16'hBEEF, 0, "R5");
    doWrite(0, 16'h1357, 0, "R5");
    readWords(4, 4, 0, "R4 sequential");
    readWords(63, 2, 0, "R4 wrap");

    runFrame({8'd0, 1'b1, 2'b01, 6'd6, 15'h1111}, 24, 0);
    checkIdle("R8 short frame");
    runFrame({6'd0, 1'b1, 2'b01, 6'd6, 17'h1_2222}, 26, 0);
    checkIdle("R8 long frame");
    readWords(6, 1, 0, "R8 discarded");

    runFrame({23'd0, 1'b1, 2'b11, 6'd5}, 9, 0);
    model[5] = 16'hFFFF;
    checkStatus("R7 erase");
    readWords(5, 1, 0, "R7 erase");

    runFrame({7'd0, 1'b1, 2'b01, 6'd7, 16'h1111}, 25, 0);
    model[7] = 16'h1111;
    csOn();
    check(serOutEn === 1'b1 && serOut === 1'b0, "R9 busy", {serOutEn, serOut}, 2'b10);
    sendBits({7'd0, 1'b1, 2'b01, 6'd8, 16'h2222}, 25, 0);
    csOff();
    checkStatus("R9 after ignored frame");
    readWords(7, 2, 0, "R9 ignored during busy");

    doSub(2'b00, 16'h0, "R2 disable");
    doWrite(9, 16'h4444, 0, "R6 after disable");
    readWords(9, 1, 0, "R6 after disable");

    doSub(2'b11, 16'h0, "R2 enable");
    doSub(2'b01, 16'h6A6A, "R7 write-all");
    readWords(62, 3, 0, "R7 write-all");
    doSub(2'b10, 16'h0, "R7 erase-all");
    readWords(20, 2, 0, "R7 erase-all");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule